// File: doc/BRIEF.md
# Infrared Serial Line Encoder and Decoder

This block sits between one UART serial core and its line pins and gives the channel a serial-infrared mode. In infrared mode the transmit side replaces every zero bit from the UART with one short high pulse, 3/16 of a bit period wide, and holds the line low otherwise. The receive side synchronises the raw line, rejects glitches, and turns each detected pulse back into a zero that lasts one bit period. The UART receiver therefore always sees ordinary NRZ data. In normal mode both directions are plain wires: the line idles high and data passes through unchanged.

The mode bit is loaded from a strap input at hardware reset and again at every soft reset. Software can write it afterwards. A polarity input selects which receive level counts as a pulse. All timing uses a single 16x bit-clock enable, `tick16`, which lasts one cycle. The data path is one bit wide and has no flow control: each direction is sampled on every clock and cannot be stalled. Because of this there is no valid/ready handshake and no back-pressure rule. All control pins are plain levels.

Top module: `sir_endec`

## Requirements
- R1: At hardware reset, `ir_mode` takes the value of `strap_ir`. A one-cycle `soft_rst` reloads `ir_mode` from `strap_ir` on the next clock edge.
- R2: When `ir_mode` is 0, `tx_pin` equals `tx_bit` and `rx_bit` equals `rx_pin` in the same cycle, with no register in the path.
- R3: When `ir_mode` is 1 and the UART sends ones, `tx_pin` stays low.
- R4: The encoder samples `tx_bit` on each `tick16`. A change starts a new bit period at phase 0; otherwise the phase advances by 1 modulo 16. While the current bit is 0, `tx_pin` is high during phases 0 to 2 only. Each zero bit therefore gives exactly one pulse, three ticks wide, and consecutive zeros give one pulse every 16 ticks.
- R5: With `rx_pol` = 0, a high `rx_pin` level is a pulse and low is idle. With `rx_pol` = 1, a low level is a pulse and high is idle.
- R6: A pulse level seen for only one clock cycle, after the two-stage synchroniser, is ignored and `rx_bit` stays 1.
- R7: A pulse level seen for two consecutive synchronised cycles drives `rx_bit` to 0 from the fourth clock edge after `rx_pin` first shows it.
- R8: After a detection, `rx_bit` stays 0 for 16 `tick16` enables and then returns to 1. A new detection during that window restarts the 16-tick count.
- R9: When `cfg_we` is 1, `ir_mode` takes `cfg_ir` on the next edge. A simultaneous `soft_rst` wins and loads the strap value instead. A soft reset also returns the encoder and decoder to their idle state.
- R10: When `ir_mode` is 1 and the receive line is idle, `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| soft_rst | input | 1 | Synchronous soft reset; reloads the strap value |
| strap_ir | input | 1 | Strap value for the infrared mode |
| cfg_we | input | 1 | Software write strobe for the mode bit |
| cfg_ir | input | 1 | Mode value written by software |
| rx_pol | input | 1 | Receive pulse polarity (0: high is a pulse) |
| tx_bit | input | 1 | NRZ transmit bit from the UART |
| tx_pin | output | 1 | Transmit line |
| rx_pin | input | 1 | Raw receive line |
| rx_bit | output | 1 | NRZ receive bit to the UART |
| ir_mode | output | 1 | Current mode bit (1: infrared) |

## Verification
The hardest case to reach is the restart of the receive hold window by a second pulse. It only shows when a new detection lands while `rx_bit` is already low, and its effect appears one bit period later. The stimulus sends two qualifying pulses 40 clocks apart and samples `rx_bit` at a point where a single window would already have closed. Glitch rejection and the polarity swap are also covered. The polarity swap itself creates a transient pulse, which the cycle model must predict exactly.

// File: rtl/sir_pkg.sv
package sir_pkg;
  typedef enum logic {MODE_NRZ = 1'b0, MODE_IR = 1'b1} sir_mode_e;

  localparam int unsigned SIR_OVS    = 16;
  localparam int unsigned SIR_PULSE  = 3;
  localparam int unsigned SIR_MIN_W  = 2;
  localparam int unsigned SIR_SYNC   = 2;
endpackage

// File: rtl/sir_mode_ctl.sv
module sir_mode_ctl
  import sir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic strap_ir,
  input  logic cfg_we,
  input  logic cfg_ir,
  output logic ir_en
);
  sir_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= sir_mode_e'(strap_ir);
    end else if (soft_rst) begin
      mode_q <= sir_mode_e'(strap_ir);
    end else if (cfg_we) begin
      mode_q <= sir_mode_e'(cfg_ir);
    end
  end

  assign ir_en = (mode_q == MODE_IR);
endmodule

// File: rtl/sir_enc.sv
module sir_enc #(
  parameter int unsigned OVS     = 16,
  parameter int unsigned PULSE_W = 3,
  parameter int unsigned PSTART  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick16,
  input  logic tx_bit,
  output logic ir_tx
);
  localparam int unsigned PHW = $clog2(OVS);

  logic           cur_q;
  logic [PHW-1:0] phase_q;
  logic [PHW-1:0] rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= 1'b1;
      phase_q <= '0;
    end else if (clr) begin
      cur_q   <= 1'b1;
      phase_q <= '0;
    end else if (tick16) begin
      if (tx_bit != cur_q) begin
        cur_q   <= tx_bit;
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  // offset from the pulse start, wrapping inside one bit period
  assign rel   = phase_q - PHW'(PSTART);
  assign ir_tx = !cur_q && (rel < PHW'(PULSE_W));
endmodule

// File: rtl/sir_dec.sv
module sir_dec #(
  parameter int unsigned OVS   = 16,
  parameter int unsigned MIN_W = 2,
  parameter int unsigned SYNC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick16,
  input  logic rx_pin,
  input  logic rx_pol,
  output logic nrz
);
  localparam int unsigned RW = $clog2(MIN_W + 1);
  localparam int unsigned WW = $clog2(OVS);

  logic [SYNC-1:0] sync_q;
  logic [RW-1:0]   run_q;
  logic [WW-1:0]   win_q;
  logic            low_q;
  logic            act;
  logic            detect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else if (clr) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], rx_pin};
    end
  end

  assign act    = sync_q[SYNC-1] ^ rx_pol;
  assign detect = act && (run_q == RW'(MIN_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clr || !act) begin
      run_q <= '0;
    end else if (run_q != RW'(MIN_W)) begin
      run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      win_q <= '0;
    end else if (clr) begin
      low_q <= 1'b0;
      win_q <= '0;
    end else if (detect) begin
      low_q <= 1'b1;
      win_q <= '0;
    end else if (low_q && tick16) begin
      if (win_q == WW'(OVS - 1)) begin
        low_q <= 1'b0;
      end else begin
        win_q <= win_q + 1'b1;
      end
    end
  end

  assign nrz = !low_q;
endmodule

// File: rtl/sir_endec.sv
module sir_endec
  import sir_pkg::*;
#(
  parameter int unsigned OVS     = SIR_OVS,
  parameter int unsigned PULSE_W = SIR_PULSE,
  parameter int unsigned PSTART  = 0,
  parameter int unsigned MIN_W   = SIR_MIN_W,
  parameter int unsigned SYNC    = SIR_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic soft_rst,
  input  logic strap_ir,
  input  logic cfg_we,
  input  logic cfg_ir,
  input  logic rx_pol,
  input  logic tx_bit,
  output logic tx_pin,
  input  logic rx_pin,
  output logic rx_bit,
  output logic ir_mode
);
  logic ir_en;
  logic enc_tx;
  logic dec_nrz;

  sir_mode_ctl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .strap_ir (strap_ir),
    .cfg_we   (cfg_we),
    .cfg_ir   (cfg_ir),
    .ir_en    (ir_en)
  );

  sir_enc #(.OVS(OVS), .PULSE_W(PULSE_W), .PSTART(PSTART)) u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (soft_rst),
    .tick16 (tick16),
    .tx_bit (tx_bit),
    .ir_tx  (enc_tx)
  );

  sir_dec #(.OVS(OVS), .MIN_W(MIN_W), .SYNC(SYNC)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (soft_rst),
    .tick16 (tick16),
    .rx_pin (rx_pin),
    .rx_pol (rx_pol),
    .nrz    (dec_nrz)
  );

  assign tx_pin  = ir_en ? enc_tx  : tx_bit;
  assign rx_bit  = ir_en ? dec_nrz : rx_pin;
  assign ir_mode = ir_en;
endmodule

// File: rtl/sir_endec_chk.sv
module sir_endec_chk #(
  parameter int unsigned PULSE_W = 3
) (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic soft_rst,
  input logic strap_ir,
  input logic cfg_we,
  input logic cfg_ir,
  input logic rx_pol,
  input logic tx_bit,
  input logic tx_pin,
  input logic rx_pin,
  input logic rx_bit,
  input logic ir_mode
);
  logic [7:0] hi_ticks;
  logic [3:0] calm_age;
  logic       pol_d, mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ticks <= '0;
    end else if (ir_mode && tx_pin) begin
      if (tick16 && hi_ticks != 8'hff) hi_ticks <= hi_ticks + 1'b1;
    end else begin
      hi_ticks <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calm_age <= '0;
      pol_d    <= 1'b0;
      mode_d   <= 1'b0;
    end else begin
      pol_d  <= rx_pol;
      mode_d <= ir_mode;
      if (pol_d != rx_pol || mode_d != ir_mode || soft_rst) calm_age <= '0;
      else if (calm_age != 4'hf) calm_age <= calm_age + 1'b1;
    end
  end

  p_strap_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ir_mode == $past(strap_ir)));

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_mode |-> (tx_pin == tx_bit && rx_bit == rx_pin));

  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ticks <= 8'(PULSE_W));

  p_glitch_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_mode && calm_age >= 4'd8 && $fell(rx_bit)) |->
      ($past(rx_pin ^ rx_pol, 3) && $past(rx_pin ^ rx_pol, 4)));

  p_cfg_override_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !soft_rst) |=> (ir_mode == $past(cfg_ir)));
endmodule

bind sir_endec sir_endec_chk #(.PULSE_W(PULSE_W)) u_chk (.*);

// File: tb/tb_sir_endec.sv
`timescale 1ns/1ps
module tb_sir_endec;
  logic clk = 1'b0;
  logic rst_n, tick16, soft_rst, strap_ir, cfg_we, cfg_ir, rx_pol;
  logic tx_bit, rx_pin;
  logic tx_pin, rx_bit, ir_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sir_endec dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .soft_rst(soft_rst),
    .strap_ir(strap_ir), .cfg_we(cfg_we), .cfg_ir(cfg_ir), .rx_pol(rx_pol),
    .tx_bit(tx_bit), .tx_pin(tx_pin), .rx_pin(rx_pin), .rx_bit(rx_bit),
    .ir_mode(ir_mode)
  );

  // behavioural reference model, updated on each clock edge
  int m_ir, m_cur, m_ph, m_s1, m_s2, m_run, m_low, m_win;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ir = strap_ir; m_cur = 1; m_ph = 0;
      m_s1 = 0; m_s2 = 0; m_run = 0; m_low = 0; m_win = 0;
    end else if (soft_rst) begin
      m_ir = strap_ir; m_cur = 1; m_ph = 0;
      m_s1 = 0; m_s2 = 0; m_run = 0; m_low = 0; m_win = 0;
    end else begin
      int act;
      act = m_s2 ^ int'(rx_pol);
      if (act == 1 && m_run == 1) begin
        m_low = 1; m_win = 0;
      end else if (m_low == 1 && tick16) begin
        if (m_win == 15) m_low = 0;
        else m_win = m_win + 1;
      end
      if (act == 1) m_run = (m_run < 2) ? m_run + 1 : 2;
      else m_run = 0;
      m_s2 = m_s1;
      m_s1 = int'(rx_pin);
      if (tick16) begin
        if (int'(tx_bit) != m_cur) begin m_cur = int'(tx_bit); m_ph = 0; end
        else m_ph = (m_ph + 1) % 16;
      end
      if (cfg_we) m_ir = int'(cfg_ir);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      int etx, erx;
      etx = (m_ir == 1) ? ((m_cur == 0 && m_ph < 3) ? 1 : 0) : int'(tx_bit);
      erx = (m_ir == 1) ? ((m_low == 1) ? 0 : 1) : int'(rx_pin);
      chk("R4", "tx_pin vs model", int'(tx_pin), etx);
      chk("R7", "rx_bit vs model", int'(rx_bit), erx);
      chk("R9", "ir_mode vs model", int'(ir_mode), m_ir);
    end
  end

  // tick generator: one enable every 4 clocks
  initial begin
    int tc = 0;
    tick16 = 1'b0;
    forever begin
      @(posedge clk); #1;
      tick16 = (tc == 3);
      tc = (tc + 1) % 4;
    end
  end

  // rising-edge counter on the transmit line
  bit cnt_en = 1'b0;
  int rises = 0;
  logic tx_prev = 1'b0;
  always @(negedge clk) begin
    if (cnt_en && tx_pin && !tx_prev) rises++;
    tx_prev = tx_pin;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    logic [9:0] frame;
    rst_n = 1'b0; strap_ir = 1'b1; soft_rst = 1'b0; cfg_we = 1'b0;
    cfg_ir = 1'b0; rx_pol = 1'b0; tx_bit = 1'b1; rx_pin = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    @(negedge clk);
    chk("R1", "strap load at reset", int'(ir_mode), 1);
    chk("R3", "ir tx idle low", int'(tx_pin), 0);
    chk("R10", "ir rx idle mark", int'(rx_bit), 1);
    step(1);

    // R4: byte 0x35 framed, LSB first: zeros are start,b1,b3,b6,b7
    frame = {1'b1, 8'h35, 1'b0};
    cnt_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tx_bit = frame[i];
      step(64);
    end
    step(40);
    cnt_en = 1'b0;
    chk("R4", "pulse count for one frame", rises, 5);
    chk("R3", "ir tx low after frame", int'(tx_pin), 0);

    // R6: one-cycle glitch
    rx_pin = 1'b1; step(1); rx_pin = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R6", "glitch ignored", int'(rx_bit), 1);
    end
    step(4);

    // R7, R8: three-cycle pulse
    rx_pin = 1'b1; step(3); rx_pin = 1'b0;
    @(negedge clk);
    chk("R7", "no output before latency", int'(rx_bit), 1);
    step(2);
    @(negedge clk);
    chk("R7", "pulse detected", int'(rx_bit), 0);
    step(70);
    @(negedge clk);
    chk("R8", "released after window", int'(rx_bit), 1);
    step(4);

    // R8: second pulse restarts the window
    rx_pin = 1'b1; step(3); rx_pin = 1'b0;
    step(40);
    rx_pin = 1'b1; step(3); rx_pin = 1'b0;
    step(30);
    @(negedge clk);
    chk("R8", "window restarted", int'(rx_bit), 0);
    step(50);
    @(negedge clk);
    chk("R8", "released after restart", int'(rx_bit), 1);
    step(2);

    // R5: inverted polarity, line idles high, low pulse is a zero
    rx_pin = 1'b1; rx_pol = 1'b1;
    step(120);
    @(negedge clk);
    chk("R5", "inverted idle mark", int'(rx_bit), 1);
    step(1);
    rx_pin = 1'b0; step(3); rx_pin = 1'b1;
    step(3);
    @(negedge clk);
    chk("R5", "low pulse detected", int'(rx_bit), 0);
    step(80);

    // R9 and R2: software clears the mode, line becomes a wire
    cfg_we = 1'b1; cfg_ir = 1'b0; step(1); cfg_we = 1'b0;
    @(negedge clk);
    chk("R9", "software write to normal", int'(ir_mode), 0);
    step(1);
    tx_bit = 1'b0; rx_pin = 1'b0;
    @(negedge clk);
    chk("R2", "bypass tx low", int'(tx_pin), 0);
    chk("R2", "bypass rx low", int'(rx_bit), 0);
    step(1);
    tx_bit = 1'b1; rx_pin = 1'b1;
    @(negedge clk);
    chk("R2", "bypass tx high", int'(tx_pin), 1);
    chk("R2", "bypass rx high", int'(rx_bit), 1);
    step(1);
    cfg_we = 1'b1; cfg_ir = 1'b1; step(1); cfg_we = 1'b0;
    @(negedge clk);
    chk("R9", "software write to infrared", int'(ir_mode), 1);
    step(1);

    // R1: soft reset reloads the strap
    strap_ir = 1'b0; soft_rst = 1'b1; step(1); soft_rst = 1'b0;
    @(negedge clk);
    chk("R1", "soft reset loads strap 0", int'(ir_mode), 0);
    step(1);
    strap_ir = 1'b1; soft_rst = 1'b1; step(1); soft_rst = 1'b0;
    @(negedge clk);
    chk("R1", "soft reset loads strap 1", int'(ir_mode), 1);
    step(1);
    // R9: soft reset beats a simultaneous write
    strap_ir = 1'b0; cfg_we = 1'b1; cfg_ir = 1'b1; soft_rst = 1'b1;
    step(1);
    cfg_we = 1'b0; soft_rst = 1'b0;
    @(negedge clk);
    chk("R9", "soft reset priority over write", int'(ir_mode), 0);
    step(4);

    // R1: hard reset with strap low
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
    @(negedge clk);
    chk("R1", "hard reset loads strap 0", int'(ir_mode), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule